// File: doc/BRIEF.md
# Serially Programmed Smart-Card Interface Controller

This block sits between a host's serial programming port and the control pins of a smart-card slot. The host lowers an active-low select, shifts one byte in most-significant bit first on the serial clock, and raises the select again. The byte carries a 3-bit command in its upper bits and a 5-bit payload in its lower bits. On commit the block updates the card-side controls: a 2-bit supply-level code, the card clock source, the card reset line, three direct-drive pins used with synchronous cards, and two configuration flags.

The command picks one of three kinds of action. Asynchronous commands set the supply level and card clock. Four of them are bank addresses checked against two strap pins, so four controllers can share one select line. Another asynchronous command targets a card on its own dedicated select. The synchronous command drives the card clock, I/O and two auxiliary contacts straight from payload bits. The configuration command sets card-detect polarity and the serial mode flag. Serial inputs are brought into the system clock domain by synchronizers. The system clock is also the card clock source, and a free-running divider supplies its half and quarter rates.

Top module: `card_if_ctrl`

## Requirements
- R1: Bits are taken MSB first on rising serial-clock edges while select is low. The command is byte bits 7..5 and the payload is bits 4..0. A byte takes effect on the rising edge of select only if exactly eight bits were taken. Any other count changes nothing.
- R2: No output state changes except when a byte is committed. Serial-clock activity while select is high is ignored.
- R3: On every committed byte, `card_rst` takes payload bit 4. This includes bank misses and the reserved command.
- R4: When an asynchronous command is applied, `vcc_sel` takes payload bits 1..0 (00 off, 01 = 1.8 V, 10 = 3.0 V, 11 = 5.0 V) and synchronous mode is cleared.
- R5: When an asynchronous command is applied, payload bits 3..2 choose the card clock: 00 holds it low, 01 passes the system clock, 10 gives half rate and 11 gives quarter rate.
- R6: Commands 000 to 011 are applied only when byte bit 5 equals `strap_s0` and byte bit 6 equals `strap_s1`. Command 100 is applied regardless of the straps.
- R7: Command 110 sets `sync_mode`. `card_c4` takes bit 1, `card_c8` bit 0, `card_clk` bit 3 and `card_io` bit 2. The supply code is left unchanged.
- R8: Command 101 with payload bits 3..0 equal to 0000 clears `det_nc`, 0001 sets it, 0010 sets `spi_special` and 0011 clears it. Other codes change neither flag, and the supply and clock are unchanged.
- R9: Command 111 changes nothing except `card_rst`.
- R10: After reset `vcc_sel` is 00, `card_clk` is held low, and `sync_mode`, `det_nc`, `spi_special`, `card_rst`, `card_io`, `card_c4` and `card_c8` are 0.
- R11: A serial-clock rise that reaches the block in the same cycle as the select rise is counted, and it completes the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock and card clock source |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial programming clock |
| mosi | input | 1 | Serial programming data |
| cs_n | input | 1 | Active-low programming select |
| strap_s0 | input | 1 | Bank address strap, compared with byte bit 5 |
| strap_s1 | input | 1 | Bank address strap, compared with byte bit 6 |
| vcc_sel | output | 2 | Card supply level code |
| card_clk | output | 1 | Card clock |
| card_rst | output | 1 | Card reset line |
| card_io | output | 1 | Card I/O drive in synchronous mode |
| card_c4 | output | 1 | Auxiliary contact C4 drive |
| card_c8 | output | 1 | Auxiliary contact C8 drive |
| sync_mode | output | 1 | Synchronous card mode active |
| det_nc | output | 1 | Card-detect switch is normally closed |
| spi_special | output | 1 | Special serial mode selected |

## Verification
The eighth serial-clock rise and the select rise can land in the same system-clock cycle. The bit counter must then count the last bit and commit the byte in that same cycle. The bench provokes this by changing `sck` and `cs_n` in the same instant, so both pass through the synchronizer together. It judges the result by the outputs: the byte's supply code and reset bit must appear. Seven-bit and nine-bit transfers show that the count is exact, because after either one the outputs must stay unchanged.

// File: rtl/card_if_pkg.sv
package card_if_pkg;

    localparam int CMD_W   = 3;
    localparam int DATA_W  = 5;
    localparam int FRAME_W = CMD_W + DATA_W;

    typedef enum logic [CMD_W-1:0] {
        CMD_BANK0 = 3'b000,
        CMD_BANK1 = 3'b001,
        CMD_BANK2 = 3'b010,
        CMD_BANK3 = 3'b011,
        CMD_EXT   = 3'b100,
        CMD_CFG   = 3'b101,
        CMD_SYNC  = 3'b110,
        CMD_RSVD  = 3'b111
    } cmd_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        CK_LOW  = 2'b00,
        CK_FULL = 2'b01,
        CK_DIV2 = 2'b10,
        CK_DIV4 = 2'b11
    } clk_sel_e;

    typedef struct packed {
        logic [1:0] vsel;
        clk_sel_e   ck;
        logic       sync_mode;
        logic       c4;
        logic       c8;
        logic       ck_bit;
        logic       io_bit;
        logic       det_nc;
        logic       spi_special;
        logic       rst;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        vsel: 2'b00, ck: CK_LOW, sync_mode: 1'b0, c4: 1'b0, c8: 1'b0,
        ck_bit: 1'b0, io_bit: 1'b0, det_nc: 1'b0, spi_special: 1'b0, rst: 1'b0
    };

    // Asynchronous command whose payload goes to supply and clock, given straps.
    function automatic logic async_applies(cmd_e cmd, logic s0, logic s1);
        if (cmd == CMD_EXT)
            return 1'b1;
        return (cmd[2] == 1'b0) && (cmd[0] == s0) && (cmd[1] == s1);
    endfunction

endpackage

// File: rtl/card_if_sync.sv
module card_if_sync #(
    parameter int             WIDTH   = 1,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= RST_VAL;
        else     pipe[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[i] <= RST_VAL;
            else     pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/card_if_rx.sv
module card_if_rx
    import card_if_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sck,
    input  logic   mosi,
    input  logic   cs_n,
    output logic   commit,
    output frame_t frame
);
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             cs_r, sck_r, mosi_r;
    logic             cs_d, sck_d;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [FRAME_W-1:0] shift, shift_n;
    logic             take, cs_rise, cs_fall;

    card_if_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sck, mosi}),
        .q   ({cs_r, sck_r, mosi_r})
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_r;
            sck_d <= sck_r;
        end
    end

    // A bit counts when select was low in the previous cycle, so a clock
    // rise that arrives together with the select rise is still taken.
    always_comb begin
        take    = sck_r & ~sck_d & ~cs_d;
        cs_rise = cs_r & ~cs_d;
        cs_fall = ~cs_r & cs_d;
        shift_n = take ? {shift[FRAME_W-2:0], mosi_r} : shift;
        cnt_n   = cnt;
        if (take && cnt != CNT_W'(CNT_MAX))
            cnt_n = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shift <= '0;
        end else begin
            cnt   <= cs_fall ? '0 : cnt_n;
            shift <= shift_n;
        end
    end

    assign commit = cs_rise && (cnt_n == CNT_W'(FRAME_W));
    assign frame  = frame_t'(shift_n);
endmodule

// File: rtl/card_if_regs.sv
module card_if_regs
    import card_if_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   commit,
    input  frame_t frame,
    input  logic   strap_s0,
    input  logic   strap_s1,
    output ctrl_t  st
);
    ctrl_t nx;

    always_comb begin
        nx = st;
        if (commit) begin
            nx.rst = frame.data[4];
            unique case (frame.cmd)
                CMD_BANK0, CMD_BANK1, CMD_BANK2, CMD_BANK3, CMD_EXT: begin
                    if (async_applies(frame.cmd, strap_s0, strap_s1)) begin
                        nx.vsel      = frame.data[1:0];
                        nx.ck        = clk_sel_e'(frame.data[3:2]);
                        nx.sync_mode = 1'b0;
                    end
                end
                CMD_SYNC: begin
                    nx.sync_mode = 1'b1;
                    nx.c4        = frame.data[1];
                    nx.c8        = frame.data[0];
                    nx.ck_bit    = frame.data[3];
                    nx.io_bit    = frame.data[2];
                end
                CMD_CFG: begin
                    case (frame.data[3:0])
                        4'b0000: nx.det_nc      = 1'b0;
                        4'b0001: nx.det_nc      = 1'b1;
                        4'b0010: nx.spi_special = 1'b1;
                        4'b0011: nx.spi_special = 1'b0;
                        default: ;
                    endcase
                end
                CMD_RSVD: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= CTRL_RESET;
        else     st <= nx;
    end
endmodule

// File: rtl/card_if_clkgen.sv
module card_if_clkgen
    import card_if_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e ck,
    input  logic     sync_mode,
    input  logic     ck_bit,
    output logic     card_clk
);
    logic [DIV_W-1:0] div;

    always_ff @(posedge clk) begin
        if (rst) div <= '0;
        else     div <= div + 1'b1;
    end

    always_comb begin
        if (sync_mode) begin
            card_clk = ck_bit;
        end else begin
            unique case (ck)
                CK_LOW:  card_clk = 1'b0;
                CK_FULL: card_clk = clk;
                CK_DIV2: card_clk = div[0];
                CK_DIV4: card_clk = div[1];
                default: card_clk = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/card_if_ctrl.sv
module card_if_ctrl
    import card_if_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       mosi,
    input  logic       cs_n,
    input  logic       strap_s0,
    input  logic       strap_s1,
    output logic [1:0] vcc_sel,
    output logic       card_clk,
    output logic       card_rst,
    output logic       card_io,
    output logic       card_c4,
    output logic       card_c8,
    output logic       sync_mode,
    output logic       det_nc,
    output logic       spi_special
);
    logic   commit;
    frame_t frame;
    ctrl_t  st;

    card_if_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .sck    (sck),
        .mosi   (mosi),
        .cs_n   (cs_n),
        .commit (commit),
        .frame  (frame)
    );

    card_if_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .frame    (frame),
        .strap_s0 (strap_s0),
        .strap_s1 (strap_s1),
        .st       (st)
    );

    card_if_clkgen u_clk (
        .clk       (clk),
        .rst       (rst),
        .ck        (st.ck),
        .sync_mode (st.sync_mode),
        .ck_bit    (st.ck_bit),
        .card_clk  (card_clk)
    );

    assign vcc_sel     = st.vsel;
    assign card_rst    = st.rst;
    assign card_io     = st.io_bit;
    assign card_c4     = st.c4;
    assign card_c8     = st.c8;
    assign sync_mode   = st.sync_mode;
    assign det_nc      = st.det_nc;
    assign spi_special = st.spi_special;
endmodule

// File: rtl/card_if_ctrl_chk.sv
module card_if_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       commit,
    input logic [7:0] frame,
    input logic       strap_s0,
    input logic       strap_s1,
    input logic [1:0] vcc_sel,
    input logic [1:0] ck_sel,
    input logic       card_clk,
    input logic       card_rst,
    input logic       card_io,
    input logic       card_c4,
    input logic       card_c8,
    input logic       sync_mode,
    input logic       det_nc,
    input logic       spi_special
);
    logic bank_hit;
    assign bank_hit = (frame[7] == 1'b0) && (frame[5] == strap_s0) && (frame[6] == strap_s1);

    a_r2_hold_between_commits: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable({vcc_sel, ck_sel, card_rst, card_io, card_c4, card_c8,
                             sync_mode, det_nc, spi_special}));

    a_r3_reset_line: assert property (@(posedge clk) disable iff (rst)
        commit |=> card_rst == $past(frame[4]));

    a_r4_supply_applied: assert property (@(posedge clk) disable iff (rst)
        commit && (bank_hit || frame[7:5] == 3'b100)
        |=> vcc_sel == $past(frame[1:0]) && !sync_mode);

    a_r6_bank_miss: assert property (@(posedge clk) disable iff (rst)
        commit && frame[7] == 1'b0 && !bank_hit |=> $stable(vcc_sel) && $stable(ck_sel));

    a_r7_sync_drive: assert property (@(posedge clk) disable iff (rst)
        commit && frame[7:5] == 3'b110
        |=> sync_mode && card_c4 == $past(frame[1]) && card_c8 == $past(frame[0])
            && card_io == $past(frame[2]) && card_clk == $past(frame[3]) && $stable(vcc_sel));

    a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
        commit && frame[7:5] == 3'b111
        |=> $stable(vcc_sel) && $stable(ck_sel) && $stable(sync_mode)
            && $stable(det_nc) && $stable(spi_special));

    a_r5_half_rate: assert property (@(posedge clk) disable iff (rst)
        ck_sel == 2'b10 && !sync_mode && $past(ck_sel) == 2'b10 && !$past(sync_mode)
        |-> card_clk != $past(card_clk));
endmodule

bind card_if_ctrl card_if_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .commit      (commit),
    .frame       (frame),
    .strap_s0    (strap_s0),
    .strap_s1    (strap_s1),
    .vcc_sel     (vcc_sel),
    .ck_sel      (st.ck),
    .card_clk    (card_clk),
    .card_rst    (card_rst),
    .card_io     (card_io),
    .card_c4     (card_c4),
    .card_c8     (card_c8),
    .sync_mode   (sync_mode),
    .det_nc      (det_nc),
    .spi_special (spi_special)
);

// File: tb/sim_card_if_ctrl.sv
`timescale 1ns/1ps
module sim_card_if_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic s0 = 1'b0, s1 = 1'b0;
    logic [1:0] vcc_sel;
    logic card_clk, card_rst, card_io, card_c4, card_c8, sync_mode, det_nc, spi_special;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected state from the requirements
    logic [1:0] e_vcc = 2'b00;
    logic [1:0] e_ck  = 2'b00;
    logic e_sync = 0, e_c4 = 0, e_c8 = 0, e_io = 0, e_ckb = 0, e_det = 0, e_spi = 0, e_rst = 0;

    always #2.5 clk = ~clk;

    card_if_ctrl u0 (
        .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .strap_s0(s0), .strap_s1(s1), .vcc_sel(vcc_sel), .card_clk(card_clk),
        .card_rst(card_rst), .card_io(card_io), .card_c4(card_c4), .card_c8(card_c8),
        .sync_mode(sync_mode), .det_nc(det_nc), .spi_special(spi_special)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Model update for a committed byte (R3..R9).
    task automatic model(input logic [7:0] b);
        logic [2:0] c;
        c = b[7:5];
        e_rst = b[4];
        if (c == 3'b100 || (c[2] == 1'b0 && c[0] == s0 && c[1] == s1)) begin
            e_vcc = b[1:0]; e_ck = b[3:2]; e_sync = 0;
        end else if (c == 3'b110) begin
            e_sync = 1; e_c4 = b[1]; e_c8 = b[0]; e_ckb = b[3]; e_io = b[2];
        end else if (c == 3'b101) begin
            case (b[3:0])
                4'b0000: e_det = 0;
                4'b0001: e_det = 1;
                4'b0010: e_spi = 1;
                4'b0011: e_spi = 0;
                default: ;
            endcase
        end
    endtask

    // Shift nbits MSB first; optionally raise select with the last clock rise.
    task automatic send(input int nbits, input logic [15:0] val, input bit coincide);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = val[i];
            wait_clk(4);
            sck = 1'b1;
            if (coincide && i == 0) cs_n = 1'b1;
            wait_clk(4);
            sck = 1'b0;
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic put(input logic [7:0] b);
        send(8, {8'h00, b}, 1'b0);
        model(b);
    endtask

    task automatic check_state(input string req);
        chk({req, " vcc_sel"}, vcc_sel, e_vcc);
        chk({req, " card_rst"}, card_rst, e_rst);
        chk({req, " sync_mode"}, sync_mode, e_sync);
        chk({req, " det_nc"}, det_nc, e_det);
        chk({req, " spi_special"}, spi_special, e_spi);
        chk({req, " card_io"}, card_io, e_io);
        chk({req, " card_c4"}, card_c4, e_c4);
        chk({req, " card_c8"}, card_c8, e_c8);
        if (e_sync) chk({req, " card_clk direct"}, card_clk, e_ckb);
    endtask

    // Card clock shape in asynchronous mode (R5).
    task automatic check_clock(input string req);
        logic smp [10];
        int bad;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            smp[i] = card_clk;
        end
        case (e_ck)
            2'b00: for (int i = 0; i < 10; i++) if (smp[i] !== 1'b0) bad++;
            2'b01: begin
                for (int i = 0; i < 4; i++) begin
                    @(posedge clk); #1; if (card_clk !== 1'b1) bad++;
                    @(negedge clk); #1; if (card_clk !== 1'b0) bad++;
                end
            end
            2'b10: for (int i = 0; i < 9; i++) if (smp[i] == smp[i+1]) bad++;
            default: for (int i = 0; i < 6; i++)
                if (smp[i] == smp[i+2] || smp[i] != smp[i+4]) bad++;
        endcase
        chk({req, " card_clk shape errors"}, bad, 0);
    endtask

    task automatic t_reset;
        check_state("R10 reset");
        check_clock("R10 reset clock low");
    endtask

    task automatic t_ext_async;
        put(8'b100_0_01_10);
        check_state("R4 ext supply 3.0V");
        check_clock("R5 pass-through");
        put(8'b100_1_10_11);
        check_state("R3 R4 reset high, supply 5.0V");
        check_clock("R5 half rate");
        put(8'b100_0_11_01);
        check_state("R4 supply 1.8V");
        check_clock("R5 quarter rate");
        put(8'b100_0_00_00);
        check_state("R4 supply off");
        check_clock("R5 held low");
    endtask

    task automatic t_bank;
        s0 = 1'b1; s1 = 1'b0;
        wait_clk(2);
        put(8'b001_0_10_10);
        chk("R6 bank 001 hit vcc", vcc_sel, 2);
        check_state("R6 bank hit");
        put(8'b010_1_01_11);
        chk("R6 bank 010 miss vcc unchanged", vcc_sel, 2);
        chk("R3 reset follows on bank miss", card_rst, 1);
        check_state("R6 bank miss");
        check_clock("R6 clock unchanged on miss");
        s0 = 1'b0; s1 = 1'b1;
        wait_clk(2);
        put(8'b010_0_00_01);
        chk("R6 bank 010 hit after strap change", vcc_sel, 1);
        check_state("R6 bank 010 hit");
        s0 = 1'b0; s1 = 1'b0;
        wait_clk(2);
    endtask

    task automatic t_sync;
        put(8'b100_0_01_11);
        put(8'b110_0_1_0_1_0);
        chk("R7 sync_mode set", sync_mode, 1);
        chk("R7 card_clk from bit3", card_clk, 1);
        chk("R7 vcc unchanged", vcc_sel, 3);
        check_state("R7 sync drive");
        put(8'b110_0_0_1_0_1);
        check_state("R7 sync drive second");
        put(8'b100_0_10_10);
        check_state("R4 async clears sync");
        check_clock("R5 half rate after sync");
    endtask

    task automatic t_cfg;
        put(8'b101_0_0001);
        chk("R8 det normally closed", det_nc, 1);
        put(8'b101_0_0010);
        chk("R8 special mode", spi_special, 1);
        put(8'b101_0_0111);
        check_state("R8 unused code ignored");
        put(8'b101_0_0011);
        chk("R8 normal mode", spi_special, 0);
        put(8'b101_0_0000);
        chk("R8 det normally open", det_nc, 0);
        check_state("R8 supply untouched");
    endtask

    task automatic t_reserved;
        put(8'b111_1_11_11);
        chk("R9 reserved sets only reset", card_rst, 1);
        check_state("R9 reserved");
        check_clock("R9 clock untouched");
    endtask

    task automatic t_bad_count;
        send(7, 16'h007F, 1'b0);
        check_state("R1 seven bits discarded");
        send(9, 16'h0193, 1'b0);
        check_state("R1 nine bits discarded");
        put(8'b100_0_01_01);
        check_state("R1 eight bits taken");
    endtask

    task automatic t_cs_high;
        for (int i = 0; i < 8; i++) begin
            mosi = i[0];
            wait_clk(4); sck = 1'b1;
            wait_clk(4); sck = 1'b0;
        end
        wait_clk(8);
        check_state("R2 clocks with select high ignored");
        check_clock("R2 clock unchanged");
    endtask

    task automatic t_coincide;
        send(8, 16'h00_9E, 1'b1);   // 100_1_11_10
        model(8'h9E);
        chk("R11 coincident last bit vcc", vcc_sel, 2);
        chk("R11 coincident last bit reset", card_rst, 1);
        check_state("R11 coincident commit");
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);
        t_reset();
        t_ext_async();
        t_bank();
        t_sync();
        t_cfg();
        t_reserved();
        t_bad_count();
        t_cs_high();
        t_coincide();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule